// File: doc/BRIEF.md
# Branch-Aware Fetch Controller

This controller decides which address the front end of a 10-stage in-order pipeline fetches each cycle, and how it reacts to conditional branches. A conditional branch is flagged by the predecoder while it sits in stage 1. Its direction and target become known at the end of stage 3. A static 2-bit input selects one of three policies. Under the first, fetch is frozen while a branch is unresolved. Under the second, fetch keeps going down the sequential path and discards the wrong-path work on a taken outcome. Under the third, the two instructions behind a branch are always executed as architectural delay slots.

The controller presents the fetch address combinationally, so on a resolution cycle the target is fetched in that same cycle. This means the work behind a resolving branch is never more than the two instructions in stages 1 and 2. It keeps a shadow of per-stage valid bits and branch tags, drives per-stage squash lines that clear those valid bits, and counts retired instructions and elapsed cycles so that CPI can be read as cycles divided by retirements.

Two states drive the control. FLOW is normal fetching. HOLD is the stall policy waiting for an outcome. FLOW goes to HOLD when the stall policy is active and a branch is in stage 1. HOLD goes back to FLOW in the cycle an accepted resolution arrives. Every other case keeps the current state.

Top module: `brf_fetch_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the fetch address equals the reset address (0), the stall output is low, all squash lines are low, and both counters read 0.
- R2: When no branch is in flight, fetch is never stalled and the fetch address rises by 4 every cycle.
- R3: With policy code 0 (stall), the stall output is high during the two cycles when a branch is in stage 1 or stage 2. In the resolution cycle, fetch resumes at the target if the branch is taken, or at the branch address plus 4 if it is not. No squash is raised.
- R4: With policy code 1 (predict not-taken) and a taken branch, squash lines 0 and 1 (stages 1 and 2) go high in the resolution cycle, and that same cycle fetches the target.
- R5: With policy code 1 and a not-taken branch, there is no stall and no squash, and fetch stays sequential.
- R6: With policy code 2 (two delay slots), the two instructions behind a branch are fetched and retired whatever the outcome. No squash or stall is ever raised. A taken target is fetched in the resolution cycle.
- R7: Policy code 3 behaves exactly like code 0.
- R8: The cycle counter equals the number of clock edges since reset. The retire counter increments once for each valid instruction leaving stage 10, so squashed instructions are never counted.
- R9: A resolution input that arrives while no branch is tracked in stage 3 is ignored. The fetch address, the stall output and the squash lines are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| policy_i | input | 2 | Static branch policy: 0 stall, 1 predict not-taken, 2 delay slots, 3 as 0 |
| br_dec_i | input | 1 | Instruction in stage 1 is a conditional branch |
| res_valid_i | input | 1 | Branch outcome presented for the stage-3 instruction |
| res_taken_i | input | 1 | Outcome is taken |
| res_target_i | input | 32 | Target address of a taken branch |
| fetch_pc_o | output | 32 | Address fetched this cycle |
| fetch_stall_o | output | 1 | No fetch this cycle |
| squash_o | output | 10 | Per-stage valid clear, bit i for stage i+1 |
| retire_cnt_o | output | 32 | Retired instruction count |
| cycle_cnt_o | output | 32 | Elapsed cycle count |

## Verification
The bench sweeps all four policy codes against both outcomes. In each run, one branch at address 0x10 is followed by one early spurious resolution, and every cycle's address, stall and squash value is compared with an arithmetic expectation. A design that fetched the target one cycle late would show an extra sequential address in cycle 7. A design that stalled for three cycles would show a bubble there. If the delay-slot policy squashed its slots, the retire count would drop by two. A controller that trusted a resolution with no branch in stage 3 would jump to 0x200 in cycle 2. The reserved code is checked cycle by cycle against the stall expectation, so a decoder that treated it as predict-not-taken would show fetches in cycles 5 and 6.

// File: rtl/brf_pkg.sv
`timescale 1ns/1ps
package brf_pkg;
    typedef enum logic [1:0] {
        POL_STALL = 2'd0,
        POL_PNT   = 2'd1,
        POL_DSLOT = 2'd2,
        POL_RSVD  = 2'd3
    } pol_e;

    typedef enum logic {
        ST_FLOW = 1'b0,
        ST_HOLD = 1'b1
    } st_e;

    function automatic pol_e pol_effective(input logic [1:0] raw);
        pol_e p;
        p = pol_e'(raw);
        return (p == POL_RSVD) ? POL_STALL : p;
    endfunction
endpackage

// File: rtl/brf_pipe_track.sv
`timescale 1ns/1ps
module brf_pipe_track #(
    parameter int NSTAGE    = 10,
    parameter int RES_STAGE = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fetch_en,
    input  logic                 br_dec,
    input  logic [NSTAGE-1:0]    squash,
    output logic [RES_STAGE-1:0] br_at,
    output logic                 retire
);
    localparam int NTAG = RES_STAGE - 1;

    logic [NSTAGE-1:0] vld_q;
    logic [NTAG-1:0]   tag_q;

    assign br_at[0] = vld_q[0] & br_dec;

    genvar g;
    generate
        for (g = 1; g < RES_STAGE; g++) begin : g_tagout
            assign br_at[g] = tag_q[g-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q[0] <= 1'b0;
        end else begin
            vld_q[0] <= fetch_en;
        end
    end

    generate
        for (g = 1; g < NSTAGE; g++) begin : g_vld
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_q[g] <= 1'b0;
                end else begin
                    vld_q[g] <= vld_q[g-1] & ~squash[g-1];
                end
            end
        end
        for (g = 0; g < NTAG; g++) begin : g_tag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tag_q[g] <= 1'b0;
                end else begin
                    tag_q[g] <= br_at[g] & ~squash[g];
                end
            end
        end
    endgenerate

    assign retire = vld_q[NSTAGE-1];

    AST_TAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        br_at[RES_STAGE-1] |-> vld_q[RES_STAGE-1]);  // R9
endmodule

// File: rtl/brf_policy_fsm.sv
`timescale 1ns/1ps
module brf_policy_fsm
    import brf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] policy,
    input  logic       br_s1,
    input  logic       res_ok,
    input  logic       res_taken,
    output logic       stall,
    output logic       redirect,
    output logic       squash_young
);
    pol_e pol;
    st_e  state_q, state_d;

    assign pol = pol_effective(policy);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FLOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d      = state_q;
        stall        = 1'b0;
        redirect     = 1'b0;
        squash_young = 1'b0;
        unique case (state_q)
            ST_FLOW: begin
                redirect = res_ok & res_taken;
                if (pol == POL_STALL && br_s1) begin
                    stall   = 1'b1;
                    state_d = ST_HOLD;
                end
                if (pol == POL_PNT && res_ok && res_taken) begin
                    squash_young = 1'b1;
                end
            end
            ST_HOLD: begin
                stall    = ~res_ok;
                redirect = res_ok & res_taken;
                if (res_ok) begin
                    state_d = ST_FLOW;
                end
            end
        endcase
    end

    AST_HOLD_ONLY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (pol == POL_STALL));  // R3
    AST_SQUASH_ONLY_PNT: assert property (@(posedge clk) disable iff (!rst_n)
        squash_young |-> (pol == POL_PNT && res_taken));  // R4
    AST_DSLOT_NO_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
        (pol == POL_DSLOT) |-> (!squash_young && !stall));  // R6
    AST_PNT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (pol == POL_PNT) |-> !stall);  // R5
endmodule

// File: rtl/brf_perf_cnt.sv
`timescale 1ns/1ps
module brf_perf_cnt #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          retire,
    output logic [CW-1:0] retire_cnt,
    output logic [CW-1:0] cycle_cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            retire_cnt <= '0;
            cycle_cnt  <= '0;
        end else begin
            cycle_cnt <= cycle_cnt + 1'b1;
            if (retire) begin
                retire_cnt <= retire_cnt + 1'b1;
            end
        end
    end

    AST_RETIRE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        retire_cnt <= cycle_cnt);  // R8
endmodule

// File: rtl/brf_fetch_ctrl.sv
`timescale 1ns/1ps
module brf_fetch_ctrl
    import brf_pkg::*;
#(
    parameter int          NSTAGE     = 10,
    parameter int          RES_STAGE  = 3,
    parameter int          AW         = 32,
    parameter int          CW         = 32,
    parameter int          INSN_BYTES = 4,
    parameter logic [31:0] RESET_PC   = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        policy_i,
    input  logic              br_dec_i,
    input  logic              res_valid_i,
    input  logic              res_taken_i,
    input  logic [AW-1:0]     res_target_i,
    output logic [AW-1:0]     fetch_pc_o,
    output logic              fetch_stall_o,
    output logic [NSTAGE-1:0] squash_o,
    output logic [CW-1:0]     retire_cnt_o,
    output logic [CW-1:0]     cycle_cnt_o
);
    localparam int NYOUNG = RES_STAGE - 1;
    localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

    logic [AW-1:0]        pc_q;
    logic [RES_STAGE-1:0] br_at;
    logic                 res_ok, stall, redirect, squash_young, retire;

    assign res_ok = res_valid_i & br_at[RES_STAGE-1];

    brf_policy_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .policy       (policy_i),
        .br_s1        (br_at[0]),
        .res_ok       (res_ok),
        .res_taken    (res_taken_i),
        .stall        (stall),
        .redirect     (redirect),
        .squash_young (squash_young)
    );

    genvar g;
    generate
        for (g = 0; g < NSTAGE; g++) begin : g_sq
            if (g < NYOUNG) begin : g_young
                assign squash_o[g] = squash_young;
            end else begin : g_old
                assign squash_o[g] = 1'b0;
            end
        end
    endgenerate

    brf_pipe_track #(.NSTAGE(NSTAGE), .RES_STAGE(RES_STAGE)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .fetch_en (~stall),
        .br_dec   (br_dec_i),
        .squash   (squash_o),
        .br_at    (br_at),
        .retire   (retire)
    );

    assign fetch_pc_o    = redirect ? res_target_i : pc_q;
    assign fetch_stall_o = stall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= AW'(RESET_PC);
        end else if (!stall) begin
            pc_q <= fetch_pc_o + STEP;
        end
    end

    brf_perf_cnt #(.CW(CW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .retire     (retire),
        .retire_cnt (retire_cnt_o),
        .cycle_cnt  (cycle_cnt_o)
    );

    AST_REDIRECT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (pc_q == $past(res_target_i) + STEP));  // R4
    AST_STALL_FREEZES_PC: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall_o |=> $stable(pc_q));  // R3
    AST_STALL_ONE_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_effective(policy_i) == POL_STALL) |-> $onehot0(br_at));  // R7
    AST_SQUASH_YOUNG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_o != '0) |-> (res_ok && res_taken_i));  // R9
endmodule

// File: tb/brf_fetch_ctrl_tb_top.sv
`timescale 1ns/1ps
module brf_fetch_ctrl_tb_top;
    localparam logic [31:0] BR_PC  = 32'h10;
    localparam logic [31:0] TGT    = 32'h100;
    localparam logic [31:0] BOGUS  = 32'h200;
    localparam int          NCYC   = 45;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  policy_i = 2'd0;
    logic        br_dec_i = 1'b0;
    logic        res_valid_i = 1'b0;
    logic        res_taken_i = 1'b0;
    logic [31:0] res_target_i = '0;
    logic [31:0] fetch_pc_o;
    logic        fetch_stall_o;
    logic [9:0]  squash_o;
    logic [31:0] retire_cnt_o, cycle_cnt_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    brf_fetch_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .policy_i(policy_i), .br_dec_i(br_dec_i),
        .res_valid_i(res_valid_i), .res_taken_i(res_taken_i),
        .res_target_i(res_target_i), .fetch_pc_o(fetch_pc_o),
        .fetch_stall_o(fetch_stall_o), .squash_o(squash_o),
        .retire_cnt_o(retire_cnt_o), .cycle_cnt_o(cycle_cnt_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (policy %0d)", req, act, exp, policy_i);
        end
    endtask

    function automatic bit is_stall_pol(input int pol);
        return (pol == 0 || pol == 3);
    endfunction

    function automatic bit exp_fetch(input int pol, input int s);
        return !(is_stall_pol(pol) && (s == 5 || s == 6));
    endfunction

    function automatic logic [31:0] exp_addr(input int pol, input bit tk, input int s);
        if (s < 7) return 32'(4 * s);
        if (is_stall_pol(pol)) return (tk ? TGT : BR_PC + 32'h4) + 32'(4 * (s - 7));
        return tk ? TGT + 32'(4 * (s - 7)) : 32'(4 * s);
    endfunction

    function automatic bit exp_squashed(input int pol, input bit tk, input int c);
        return (pol == 1) && tk && (c == 5 || c == 6);
    endfunction

    function automatic string pol_tag(input int pol, input bit tk);
        case (pol)
            0: return "R3";
            1: return tk ? "R4" : "R5";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic run_case(input int pol, input bit tk);
        logic [31:0] fetched [0:NCYC-1];
        bit          fv      [0:NCYC-1];
        string       tag;
        int          ret_exp;
        tag = pol_tag(pol, tk);
        rst_n = 1'b0;
        policy_i = 2'(pol);
        br_dec_i = 1'b0;
        res_valid_i = 1'b0;
        res_taken_i = 1'b0;
        res_target_i = '0;
        repeat (2) @(negedge clk);
        #1;
        // R1 reset values
        chk("R1", fetch_pc_o, 32'h0);
        chk("R1", {31'b0, fetch_stall_o}, 32'h0);
        chk("R1", {22'b0, squash_o}, 32'h0);
        chk("R1", retire_cnt_o, 32'h0);
        chk("R1", cycle_cnt_o, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < NCYC; s++) begin
            br_dec_i = (s >= 1) && fv[s-1] && (fetched[s-1] == BR_PC);
            if (s >= 3 && fv[s-3] && fetched[s-3] == BR_PC) begin
                res_valid_i = 1'b1; res_taken_i = tk; res_target_i = TGT;
            end else if (s == 2) begin
                res_valid_i = 1'b1; res_taken_i = 1'b1; res_target_i = BOGUS;
            end else begin
                res_valid_i = 1'b0; res_taken_i = 1'b0; res_target_i = '0;
            end
            #1;
            if (s == 0) chk("R1", cycle_cnt_o, 32'h0);
            begin
                string t;
                t = (s == 2) ? "R9" : (s < 5) ? "R2" : tag;
                chk(t, {31'b0, fetch_stall_o}, {31'b0, ~exp_fetch(pol, s)});
                if (exp_fetch(pol, s)) chk(t, fetch_pc_o, exp_addr(pol, tk, s));
                chk(t, {22'b0, squash_o},
                    (s == 7 && pol == 1 && tk) ? 32'h3 : 32'h0);
            end
            if (s == 20 || s == 40) begin
                ret_exp = 0;
                for (int c = 0; c + 11 <= s; c++)
                    if (exp_fetch(pol, c) && !exp_squashed(pol, tk, c)) ret_exp++;
                chk("R8", retire_cnt_o, 32'(ret_exp));
                chk("R8", cycle_cnt_o, 32'(s));
            end
            fv[s] = !fetch_stall_o;
            fetched[s] = fetch_pc_o;
            @(negedge clk);
        end
    endtask

    initial begin
        for (int p = 0; p < 4; p++) begin
            for (int t = 0; t < 2; t++) begin
                run_case(p, t[0]);
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule